// File: doc/BRIEF.md
# Audio Serial Port Register Interface

This block is the bus-facing control plane of a serial audio port that carries up to four stereo channel pairs. An APB master programs a handful of common controls (global enable, receive-block and transmit-block enables, clock enable and a clock configuration field) and, for each pair, its own bank of registers: receive and transmit enables, sample resolution codes, FIFO trigger levels, an interrupt mask and strobes that flush that pair's FIFOs. The registered values are driven straight out to the pair FIFOs and serializers, which live outside this block.

In the other direction, the block takes each pair's FIFO fill levels and one-cycle overrun events. It turns them into a per-pair interrupt status word and raises interrupt lines. Overrun status is sticky and is cleared as a side effect of reading a dedicated per-pair register. Two read-only words at the top of the map describe how the port was built: the pair count, the word-size codes, the FIFO depth, the bus width and the clocking role.

The bus has no wait states. A write takes effect on the clock edge of its access phase. A read returns data combinationally during the access phase.

Top module: `audio_port_regif`

## Requirements
- R1: After reset every control output is 0, no flush pulse or interrupt is active, every writable register reads 0, and each pair's mask register reads 0x33 (all four mask bits set).
- R2: The common registers sit at 0x00 (global enable, bit 0), 0x04 (receive-block enable, bit 0), 0x08 (transmit-block enable, bit 0), 0x0C (clock enable, bit 0) and 0x10 (clock configuration, bits 4:0). Each reads back what was written, and its output changes in the cycle after the write access and at no other time.
- R3: Pair p's bank starts at 0x20 + 0x40*p. Within a bank, the receive and transmit enables are at +0x08 and +0x0C (bit 0), and the receive and transmit trigger levels are at +0x28 and +0x2C. A write to one bank changes only that pair's outputs. Any address inside the bank area of a pair that is not built reads 0.
- R4: The receive and transmit resolution registers (+0x10 and +0x14, bits 2:0) accept only code 2 (16-bit), 4 (24-bit) or 5 (32-bit). A write with any other code leaves the register unchanged.
- R5: Writing 1 in bit 0 of 0x14 or 0x18 pulses every pair's receive or transmit flush output for exactly one cycle. Writing 1 in bit 0 of a bank's +0x30 or +0x34 pulses only that pair's receive or transmit flush. Writing 0 there produces no pulse, and flush registers read 0.
- R6: Interrupt status (+0x18) bit 0 is 1 while the pair's receive level is above its receive trigger level. Bit 4 is 1 while the pair's transmit level is at or below its transmit trigger level.
- R7: Status bit 1 (receive overrun) and bit 5 (transmit overrun) are set by an overrun event and stay set. A read of +0x20 returns the receive overrun flag in bit 0 and clears it. A read of +0x24 does the same for transmit overrun. An event in the same cycle as the clearing read leaves the flag set.
- R8: The mask register (+0x1C) gates receive status bits 1:0 with its bits 1:0 and transmit status bits 5:4 with its bits 5:4, where 1 suppresses. A pair's interrupt is high when the global enable is 1 and an unmasked receive bit is set with that pair's receive enable at 1, or an unmasked transmit bit is set with its transmit enable at 1. The combined interrupt is the OR of the pair interrupts.
- R9: The word at 0x1F4 reads transmit word-size codes in bits 27:16 (3 bits per pair, pair 0 lowest), transmit and receive pair count minus one in bits 10:9 and 8:7, receive and transmit present in bits 6 and 5, master role in bit 4, FIFO depth as log2(depth)-1 in bits 3:2, and bus width code 2 in bits 1:0. The word at 0x1F0 reads the receive word-size codes in bits 2:0, 5:3, 9:7 and 12:10. Writes to either word are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| psel | input | 1 | APB select |
| penable | input | 1 | APB access phase |
| pwrite | input | 1 | APB write (1) or read (0) |
| paddr | input | ADDR_W | APB byte address |
| pwdata | input | 32 | APB write data |
| prdata | output | 32 | APB read data |
| txLevel | input | NUM_PAIRS*LvlW | Transmit FIFO fill level per pair |
| rxLevel | input | NUM_PAIRS*LvlW | Receive FIFO fill level per pair |
| txOverrun | input | NUM_PAIRS | Transmit overrun event per pair |
| rxOverrun | input | NUM_PAIRS | Receive overrun event per pair |
| globalEn | output | 1 | Global enable |
| rxBlockEn | output | 1 | Receive block enable |
| txBlockEn | output | 1 | Transmit block enable |
| clkEn | output | 1 | Serial clock enable |
| clkCfg | output | 5 | Clock configuration |
| pairRxEn | output | NUM_PAIRS | Receive enable per pair |
| pairTxEn | output | NUM_PAIRS | Transmit enable per pair |
| pairRxRes | output | NUM_PAIRS*3 | Receive resolution code per pair |
| pairTxRes | output | NUM_PAIRS*3 | Transmit resolution code per pair |
| pairRxTrig | output | NUM_PAIRS*TrigW | Receive trigger level per pair |
| pairTxTrig | output | NUM_PAIRS*TrigW | Transmit trigger level per pair |
| pairRxFlush | output | NUM_PAIRS | One-cycle receive FIFO flush per pair |
| pairTxFlush | output | NUM_PAIRS | One-cycle transmit FIFO flush per pair |
| irqPair | output | NUM_PAIRS | Interrupt per pair |
| irq | output | 1 | Combined interrupt |

## Verification
The bench targets the places where a plausible mistake would go unnoticed in normal use.

- Stride arithmetic. The pair stride is checked on pairs 2 and 3 and one address past the last pair. A decoder that ignored the 0x20 base offset would enable the wrong pair, or would alias a missing pair onto a real one.
- Clearing reads. The clear-on-read flag is read twice, and a read is also overlapped with a new overrun event. A design that cleared on the address phase, or let the clear win over the set, would lose an overrun.
- Mask polarity and placement. The mask tests unmask the receive field, the transmit-level bit and the transmit-overrun bit one at a time, so swapped mask fields or inverted polarity show up directly on the interrupt pins.
- Pulse width and scope. Flush pulses are sampled for both their width and their scope. A flush that held its state, or that reached the wrong pairs, fails there.

// File: rtl/audio_port_pkg.sv
package audio_port_pkg;

  localparam int MAX_PAIRS = 4;

  // Bus strobes handed from the address decoder to the register datapath.
  typedef struct packed {
    logic                 wr;
    logic                 rd;
    logic                 commonHit;
    logic                 paramHit;
    logic [MAX_PAIRS-1:0] pairHit;
    logic [3:0]           regIdx;
  } busStrobe_t;

  function automatic logic resCodeOk(input logic [2:0] code);
    return (code == 3'd2) || (code == 3'd4) || (code == 3'd5);
  endfunction

endpackage

// File: rtl/audio_port_decode.sv
module audio_port_decode
  import audio_port_pkg::*;
#(
  parameter int ADDR_W    = 9,
  parameter int NUM_PAIRS = 4
) (
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  output busStrobe_t        strobe
);

  localparam logic [ADDR_W-1:0] CommonEnd = ADDR_W'(32'h1C);
  localparam logic [ADDR_W-1:0] BankBase  = ADDR_W'(32'h20);
  localparam logic [ADDR_W-4:0] ParamRow  = (ADDR_W-3)'(32'h1F0 >> 3);
  localparam logic [ADDR_W-7:0] PairCount = (ADDR_W-6)'(NUM_PAIRS);

  logic [ADDR_W-1:0] rel;
  logic              bankHit;
  logic              unusedAddr;

  assign rel        = paddr - BankBase;
  assign bankHit    = (paddr >= BankBase) && (rel[ADDR_W-1:6] < PairCount) && (rel[5:2] <= 4'd13);
  assign unusedAddr = ^{paddr[1:0], rel[1:0]};

  always_comb begin
    strobe    = '0;
    strobe.wr = psel && penable && pwrite;
    strobe.rd = psel && penable && !pwrite;
    if (paddr < CommonEnd) begin
      strobe.commonHit = 1'b1;
      strobe.regIdx    = {1'b0, paddr[4:2]};
    end else if (bankHit) begin
      for (int p = 0; p < NUM_PAIRS; p++)
        strobe.pairHit[p] = (rel[ADDR_W-1:6] == (ADDR_W-6)'(p));
      strobe.regIdx = rel[5:2];
    end else if (paddr[ADDR_W-1:3] == ParamRow) begin
      strobe.paramHit = 1'b1;
      strobe.regIdx   = {3'b000, paddr[2]};
    end
  end

endmodule

// File: rtl/audio_port_regs.sv
module audio_port_regs
  import audio_port_pkg::*;
#(
  parameter int NUM_PAIRS  = 4,
  parameter int FIFO_DEPTH = 16,
  parameter int WORD_CODE  = 4,
  parameter int MASTER     = 1,
  parameter int TrigW      = 4,
  parameter int LvlW       = 5
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  busStrobe_t                 strobe,
  input  logic [31:0]                pwdata,
  output logic [31:0]                prdata,
  input  logic [NUM_PAIRS*LvlW-1:0]  txLevel,
  input  logic [NUM_PAIRS*LvlW-1:0]  rxLevel,
  input  logic [NUM_PAIRS-1:0]       txOverrun,
  input  logic [NUM_PAIRS-1:0]       rxOverrun,
  output logic                       globalEn,
  output logic                       rxBlockEn,
  output logic                       txBlockEn,
  output logic                       clkEn,
  output logic [4:0]                 clkCfg,
  output logic [NUM_PAIRS-1:0]       pairRxEn,
  output logic [NUM_PAIRS-1:0]       pairTxEn,
  output logic [NUM_PAIRS*3-1:0]     pairRxRes,
  output logic [NUM_PAIRS*3-1:0]     pairTxRes,
  output logic [NUM_PAIRS*TrigW-1:0] pairRxTrig,
  output logic [NUM_PAIRS*TrigW-1:0] pairTxTrig,
  output logic [NUM_PAIRS-1:0]       pairRxFlush,
  output logic [NUM_PAIRS-1:0]       pairTxFlush,
  output logic [NUM_PAIRS-1:0]       irqPair
);

  localparam logic [2:0]  Ws0   = 3'(WORD_CODE);
  localparam logic [2:0]  Ws1   = (NUM_PAIRS > 1) ? Ws0 : 3'd0;
  localparam logic [2:0]  Ws2   = (NUM_PAIRS > 2) ? Ws0 : 3'd0;
  localparam logic [2:0]  Ws3   = (NUM_PAIRS > 3) ? Ws0 : 3'd0;
  localparam logic [1:0]  ChCnt = 2'(NUM_PAIRS - 1);
  localparam logic [1:0]  DepF  = 2'($clog2(FIFO_DEPTH) - 1);
  localparam logic [31:0] Comp1 = {4'b0, Ws3, Ws2, Ws1, Ws0, 5'b0, ChCnt, ChCnt,
                                   1'b1, 1'b1, 1'(MASTER), DepF, 2'd2};
  localparam logic [31:0] Comp2 = {19'b0, Ws3, Ws2, 1'b0, Ws1, Ws0};

  logic        globalEnR, rxBlkR, txBlkR, clkEnR;
  logic [4:0]  clkCfgR;
  logic        rxFlAllR, txFlAllR;
  logic        wrCommon;
  logic [31:0] pairRd [NUM_PAIRS];
  logic        unusedData;

  assign wrCommon   = strobe.wr && strobe.commonHit;
  assign unusedData = ^pwdata[31:6];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      globalEnR <= 1'b0;
      rxBlkR    <= 1'b0;
      txBlkR    <= 1'b0;
      clkEnR    <= 1'b0;
      clkCfgR   <= '0;
      rxFlAllR  <= 1'b0;
      txFlAllR  <= 1'b0;
    end else begin
      rxFlAllR <= wrCommon && (strobe.regIdx == 4'd5) && pwdata[0];
      txFlAllR <= wrCommon && (strobe.regIdx == 4'd6) && pwdata[0];
      if (wrCommon) begin
        case (strobe.regIdx)
          4'd0:    globalEnR <= pwdata[0];
          4'd1:    rxBlkR    <= pwdata[0];
          4'd2:    txBlkR    <= pwdata[0];
          4'd3:    clkEnR    <= pwdata[0];
          4'd4:    clkCfgR   <= pwdata[4:0];
          default: ;
        endcase
      end
    end
  end

  assign globalEn  = globalEnR;
  assign rxBlockEn = rxBlkR;
  assign txBlockEn = txBlkR;
  assign clkEn     = clkEnR;
  assign clkCfg    = clkCfgR;

  for (genvar p = 0; p < NUM_PAIRS; p++) begin : gPair
    logic             wrP, rdP;
    logic             rxEnR, txEnR, rxOvrR, txOvrR, rxFlR, txFlR;
    logic [2:0]       rxResR, txResR;
    logic [TrigW-1:0] rxTrigR, txTrigR;
    logic [3:0]       maskR;
    logic             rxAvail, txLow;
    logic [31:0]      rdData;

    assign wrP = strobe.wr && strobe.pairHit[p];
    assign rdP = strobe.rd && strobe.pairHit[p];

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        rxEnR   <= 1'b0;
        txEnR   <= 1'b0;
        rxResR  <= '0;
        txResR  <= '0;
        rxTrigR <= '0;
        txTrigR <= '0;
        maskR   <= 4'hF;
        rxOvrR  <= 1'b0;
        txOvrR  <= 1'b0;
        rxFlR   <= 1'b0;
        txFlR   <= 1'b0;
      end else begin
        rxFlR <= wrP && (strobe.regIdx == 4'd12) && pwdata[0];
        txFlR <= wrP && (strobe.regIdx == 4'd13) && pwdata[0];
        if (wrP) begin
          case (strobe.regIdx)
            4'd2:    rxEnR <= pwdata[0];
            4'd3:    txEnR <= pwdata[0];
            4'd4:    if (resCodeOk(pwdata[2:0])) rxResR <= pwdata[2:0];
            4'd5:    if (resCodeOk(pwdata[2:0])) txResR <= pwdata[2:0];
            4'd7:    maskR <= {pwdata[5:4], pwdata[1:0]};
            4'd10:   rxTrigR <= pwdata[TrigW-1:0];
            4'd11:   txTrigR <= pwdata[TrigW-1:0];
            default: ;
          endcase
        end
        if (rxOverrun[p])                          rxOvrR <= 1'b1;
        else if (rdP && (strobe.regIdx == 4'd8))   rxOvrR <= 1'b0;
        if (txOverrun[p])                          txOvrR <= 1'b1;
        else if (rdP && (strobe.regIdx == 4'd9))   txOvrR <= 1'b0;
      end
    end

    assign rxAvail = rxLevel[p*LvlW +: LvlW] >  LvlW'(rxTrigR);
    assign txLow   = txLevel[p*LvlW +: LvlW] <= LvlW'(txTrigR);

    always_comb begin
      case (strobe.regIdx)
        4'd2:    rdData = {31'b0, rxEnR};
        4'd3:    rdData = {31'b0, txEnR};
        4'd4:    rdData = {29'b0, rxResR};
        4'd5:    rdData = {29'b0, txResR};
        4'd6:    rdData = {26'b0, txOvrR, txLow, 2'b0, rxOvrR, rxAvail};
        4'd7:    rdData = {26'b0, maskR[3:2], 2'b0, maskR[1:0]};
        4'd8:    rdData = {31'b0, rxOvrR};
        4'd9:    rdData = {31'b0, txOvrR};
        4'd10:   rdData = 32'(rxTrigR);
        4'd11:   rdData = 32'(txTrigR);
        default: rdData = '0;
      endcase
    end

    assign pairRd[p] = strobe.pairHit[p] ? rdData : '0;

    assign irqPair[p] = globalEnR &&
                        ((rxEnR && |({rxOvrR, rxAvail} & ~maskR[1:0])) ||
                         (txEnR && |({txOvrR, txLow}   & ~maskR[3:2])));

    assign pairRxEn[p]                  = rxEnR;
    assign pairTxEn[p]                  = txEnR;
    assign pairRxRes[p*3 +: 3]          = rxResR;
    assign pairTxRes[p*3 +: 3]          = txResR;
    assign pairRxTrig[p*TrigW +: TrigW] = rxTrigR;
    assign pairTxTrig[p*TrigW +: TrigW] = txTrigR;
    assign pairRxFlush[p]               = rxFlR || rxFlAllR;
    assign pairTxFlush[p]               = txFlR || txFlAllR;
  end

  always_comb begin
    prdata = '0;
    if (strobe.commonHit) begin
      case (strobe.regIdx)
        4'd0:    prdata = {31'b0, globalEnR};
        4'd1:    prdata = {31'b0, rxBlkR};
        4'd2:    prdata = {31'b0, txBlkR};
        4'd3:    prdata = {31'b0, clkEnR};
        4'd4:    prdata = {27'b0, clkCfgR};
        default: prdata = '0;
      endcase
    end else if (strobe.paramHit) begin
      prdata = strobe.regIdx[0] ? Comp1 : Comp2;
    end else begin
      for (int p = 0; p < NUM_PAIRS; p++) prdata = prdata | pairRd[p];
    end
  end

endmodule

// File: rtl/audio_port_regif.sv
module audio_port_regif
  import audio_port_pkg::*;
#(
  parameter int  ADDR_W     = 9,
  parameter int  NUM_PAIRS  = 4,
  parameter int  FIFO_DEPTH = 16,
  parameter int  WORD_CODE  = 4,
  parameter int  MASTER     = 1,
  localparam int TrigW      = $clog2(FIFO_DEPTH),
  localparam int LvlW       = $clog2(FIFO_DEPTH + 1)
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       psel,
  input  logic                       penable,
  input  logic                       pwrite,
  input  logic [ADDR_W-1:0]          paddr,
  input  logic [31:0]                pwdata,
  output logic [31:0]                prdata,
  input  logic [NUM_PAIRS*LvlW-1:0]  txLevel,
  input  logic [NUM_PAIRS*LvlW-1:0]  rxLevel,
  input  logic [NUM_PAIRS-1:0]       txOverrun,
  input  logic [NUM_PAIRS-1:0]       rxOverrun,
  output logic                       globalEn,
  output logic                       rxBlockEn,
  output logic                       txBlockEn,
  output logic                       clkEn,
  output logic [4:0]                 clkCfg,
  output logic [NUM_PAIRS-1:0]       pairRxEn,
  output logic [NUM_PAIRS-1:0]       pairTxEn,
  output logic [NUM_PAIRS*3-1:0]     pairRxRes,
  output logic [NUM_PAIRS*3-1:0]     pairTxRes,
  output logic [NUM_PAIRS*TrigW-1:0] pairRxTrig,
  output logic [NUM_PAIRS*TrigW-1:0] pairTxTrig,
  output logic [NUM_PAIRS-1:0]       pairRxFlush,
  output logic [NUM_PAIRS-1:0]       pairTxFlush,
  output logic [NUM_PAIRS-1:0]       irqPair,
  output logic                       irq
);

  busStrobe_t strobe;

  audio_port_decode #(.ADDR_W(ADDR_W), .NUM_PAIRS(NUM_PAIRS)) uDecode (
    .psel(psel), .penable(penable), .pwrite(pwrite), .paddr(paddr), .strobe(strobe)
  );

  audio_port_regs #(
    .NUM_PAIRS(NUM_PAIRS), .FIFO_DEPTH(FIFO_DEPTH), .WORD_CODE(WORD_CODE),
    .MASTER(MASTER), .TrigW(TrigW), .LvlW(LvlW)
  ) uRegs (
    .clk(clk), .rstN(rstN), .strobe(strobe), .pwdata(pwdata), .prdata(prdata),
    .txLevel(txLevel), .rxLevel(rxLevel), .txOverrun(txOverrun), .rxOverrun(rxOverrun),
    .globalEn(globalEn), .rxBlockEn(rxBlockEn), .txBlockEn(txBlockEn), .clkEn(clkEn),
    .clkCfg(clkCfg), .pairRxEn(pairRxEn), .pairTxEn(pairTxEn), .pairRxRes(pairRxRes),
    .pairTxRes(pairTxRes), .pairRxTrig(pairRxTrig), .pairTxTrig(pairTxTrig),
    .pairRxFlush(pairRxFlush), .pairTxFlush(pairTxFlush), .irqPair(irqPair)
  );

  assign irq = |irqPair;

endmodule

// File: rtl/audio_port_regif_checker.sv
module audio_port_regif_checker
  import audio_port_pkg::*;
#(
  parameter int NUM_PAIRS = 4
) (
  input logic                   clk,
  input logic                   rstN,
  input logic                   psel,
  input logic                   penable,
  input logic                   pwrite,
  input logic                   globalEn,
  input logic                   rxBlockEn,
  input logic                   txBlockEn,
  input logic                   clkEn,
  input logic [4:0]             clkCfg,
  input logic [NUM_PAIRS-1:0]   pairRxEn,
  input logic [NUM_PAIRS-1:0]   pairTxEn,
  input logic [NUM_PAIRS*3-1:0] pairRxRes,
  input logic [NUM_PAIRS*3-1:0] pairTxRes,
  input logic [NUM_PAIRS-1:0]   pairRxFlush,
  input logic [NUM_PAIRS-1:0]   pairTxFlush,
  input logic [NUM_PAIRS-1:0]   irqPair,
  input logic                   irq
);

  // R2: control state only moves after a write access
  assert_ctrl_hold_R2: assert property (@(posedge clk) disable iff (!rstN)
    !$past(psel && penable && pwrite) |->
      $stable({globalEn, rxBlockEn, txBlockEn, clkEn, clkCfg, pairRxEn, pairTxEn, pairRxRes, pairTxRes}));

  // R5: a flush pulse is always caused by the write access just before it
  assert_flush_cause_R5: assert property (@(posedge clk) disable iff (!rstN)
    (|{pairRxFlush, pairTxFlush}) |-> $past(psel && penable && pwrite));

  // R8: no interrupt without the global enable
  assert_irq_gate_R8: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> globalEn);

  for (genvar p = 0; p < NUM_PAIRS; p++) begin : gChk
    // R4: resolution fields hold only a legal code or their reset value
    assert_res_legal_R4: assert property (@(posedge clk) disable iff (!rstN)
      (resCodeOk(pairRxRes[p*3 +: 3]) || pairRxRes[p*3 +: 3] == 3'd0) &&
      (resCodeOk(pairTxRes[p*3 +: 3]) || pairTxRes[p*3 +: 3] == 3'd0));

    // R8: a pair interrupt needs one of that pair's direction enables
    assert_irq_pair_R8: assert property (@(posedge clk) disable iff (!rstN)
      irqPair[p] |-> (pairRxEn[p] || pairTxEn[p]));
  end

endmodule

bind audio_port_regif audio_port_regif_checker #(.NUM_PAIRS(NUM_PAIRS)) uChecker (
  .clk(clk), .rstN(rstN), .psel(psel), .penable(penable), .pwrite(pwrite),
  .globalEn(globalEn), .rxBlockEn(rxBlockEn), .txBlockEn(txBlockEn), .clkEn(clkEn),
  .clkCfg(clkCfg), .pairRxEn(pairRxEn), .pairTxEn(pairTxEn), .pairRxRes(pairRxRes),
  .pairTxRes(pairTxRes), .pairRxFlush(pairRxFlush), .pairTxFlush(pairTxFlush),
  .irqPair(irqPair), .irq(irq)
);

// File: tb/audio_port_regif_test.sv
module audio_port_regif_test;

  localparam int NP    = 4;
  localparam int LvlW  = 5;
  localparam int TrigW = 4;

  logic                 clk = 1'b0;
  logic                 rstN = 1'b0;
  logic                 psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
  logic [8:0]           paddr = '0;
  logic [31:0]          pwdata = '0;
  logic [31:0]          prdata;
  logic [NP*LvlW-1:0]   txLevel = {NP{5'd16}};
  logic [NP*LvlW-1:0]   rxLevel = '0;
  logic [NP-1:0]        txOverrun = '0, rxOverrun = '0;
  logic                 globalEn, rxBlockEn, txBlockEn, clkEn, irq;
  logic [4:0]           clkCfg;
  logic [NP-1:0]        pairRxEn, pairTxEn, pairRxFlush, pairTxFlush, irqPair;
  logic [NP*3-1:0]      pairRxRes, pairTxRes;
  logic [NP*TrigW-1:0]  pairRxTrig, pairTxTrig;

  int checks = 0;
  int fails  = 0;

  always #2 clk = ~clk;

  audio_port_regif uut (
    .clk(clk), .rstN(rstN), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .txLevel(txLevel), .rxLevel(rxLevel),
    .txOverrun(txOverrun), .rxOverrun(rxOverrun), .globalEn(globalEn), .rxBlockEn(rxBlockEn),
    .txBlockEn(txBlockEn), .clkEn(clkEn), .clkCfg(clkCfg), .pairRxEn(pairRxEn),
    .pairTxEn(pairTxEn), .pairRxRes(pairRxRes), .pairTxRes(pairTxRes),
    .pairRxTrig(pairRxTrig), .pairTxTrig(pairTxTrig), .pairRxFlush(pairRxFlush),
    .pairTxFlush(pairTxFlush), .irqPair(irqPair), .irq(irq)
  );

  task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic apbWrite(input logic [8:0] a, input logic [31:0] d);
    @(negedge clk);
    psel = 1'b1; penable = 1'b0; pwrite = 1'b1; paddr = a; pwdata = d;
    @(negedge clk);
    penable = 1'b1;
    @(negedge clk);
    psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
  endtask

  task automatic apbRead(input logic [8:0] a, output logic [31:0] d);
    @(negedge clk);
    psel = 1'b1; penable = 1'b0; pwrite = 1'b0; paddr = a;
    @(negedge clk);
    penable = 1'b1;
    #1 d = prdata;
    @(negedge clk);
    psel = 1'b0; penable = 1'b0;
  endtask

  task automatic readCheck(input string req, input logic [8:0] a, input logic [31:0] exp);
    logic [31:0] d;
    apbRead(a, d);
    check(req, $sformatf("read 0x%0h", a), d, exp);
  endtask

  task automatic testReset;
    check("R1", "control outputs", {27'b0, globalEn, rxBlockEn, txBlockEn, clkEn, irq}, 32'h0);
    check("R1", "pair outputs", {pairRxEn, pairTxEn, pairRxFlush, pairTxFlush, irqPair}, 32'h0);
    check("R1", "res and trig", {pairRxRes, pairTxRes}, 32'h0);
    readCheck("R1", 9'h3C, 32'h33);
    readCheck("R1", 9'h10, 32'h0);
  endtask

  task automatic testCommon;
    apbWrite(9'h00, 1);
    check("R2", "globalEn", {31'b0, globalEn}, 1);
    check("R2", "others untouched", {29'b0, rxBlockEn, txBlockEn, clkEn}, 0);
    apbWrite(9'h04, 1);
    apbWrite(9'h08, 1);
    apbWrite(9'h0C, 1);
    apbWrite(9'h10, 32'hFF);
    check("R2", "block and clock enables", {29'b0, rxBlockEn, txBlockEn, clkEn}, 3'b111);
    check("R2", "clkCfg", {27'b0, clkCfg}, 32'h1F);
    apbWrite(9'h10, 32'h15);
    readCheck("R2", 9'h10, 32'h15);
    readCheck("R2", 9'h08, 32'h1);
  endtask

  task automatic testPairBank;
    apbWrite(9'hA8, 1);
    check("R3", "pair 2 rx enable only", {28'b0, pairRxEn}, 32'h4);
    apbWrite(9'h10C, 9);
    check("R3", "pair 3 tx trigger", {16'b0, pairTxTrig}, 32'h9000);
    readCheck("R3", 9'h10C, 32'h9);
    readCheck("R3", 9'h128, 32'h0);
    apbWrite(9'hA8, 0);
    check("R3", "pair 2 rx enable cleared", {28'b0, pairRxEn}, 32'h0);
  endtask

  task automatic testResolution;
    apbWrite(9'h74, 5);
    check("R4", "pair 1 tx res 32-bit", {20'b0, pairTxRes}, 32'h28);
    apbWrite(9'h74, 3);
    check("R4", "illegal code ignored", {20'b0, pairTxRes}, 32'h28);
    apbWrite(9'h74, 2);
    readCheck("R4", 9'h74, 32'h2);
    apbWrite(9'h30, 4);
    readCheck("R4", 9'h30, 32'h4);
  endtask

  task automatic testFlush;
    apbWrite(9'h18, 1);
    check("R5", "all tx flush pulse", {24'b0, pairTxFlush, pairRxFlush}, 32'hF0);
    @(negedge clk);
    check("R5", "tx flush one cycle", {28'b0, pairTxFlush}, 32'h0);
    apbWrite(9'h90, 1);
    check("R5", "pair 1 rx flush only", {24'b0, pairTxFlush, pairRxFlush}, 32'h02);
    @(negedge clk);
    check("R5", "rx flush one cycle", {28'b0, pairRxFlush}, 32'h0);
    apbWrite(9'h14, 0);
    check("R5", "zero write no pulse", {24'b0, pairTxFlush, pairRxFlush}, 32'h0);
    readCheck("R5", 9'h14, 32'h0);
  endtask

  task automatic testStatus;
    apbWrite(9'h48, 3);
    apbWrite(9'h4C, 2);
    rxLevel[0 +: LvlW] = 5'd3;
    txLevel[0 +: LvlW] = 5'd3;
    readCheck("R6", 9'h38, 32'h00);
    rxLevel[0 +: LvlW] = 5'd4;
    txLevel[0 +: LvlW] = 5'd2;
    readCheck("R6", 9'h38, 32'h11);
  endtask

  task automatic testOverrun;
    @(negedge clk); rxOverrun[1] = 1'b1;
    @(negedge clk); rxOverrun[1] = 1'b0;
    readCheck("R7", 9'h78, 32'h02);
    readCheck("R7", 9'h80, 32'h1);
    readCheck("R7", 9'h78, 32'h00);
    readCheck("R7", 9'h80, 32'h0);
    txOverrun[1] = 1'b1;
    readCheck("R7", 9'h84, 32'h1);
    txOverrun[1] = 1'b0;
    readCheck("R7", 9'h78, 32'h20);
    readCheck("R7", 9'h84, 32'h1);
    readCheck("R7", 9'h78, 32'h00);
  endtask

  task automatic testIrq;
    check("R8", "no irq while pair disabled", {27'b0, irqPair, irq}, 0);
    apbWrite(9'h28, 1);
    check("R8", "masked rx status", {27'b0, irqPair, irq}, 0);
    apbWrite(9'h3C, 32'h32);
    check("R8", "unmasked rx avail", {27'b0, irqPair, irq}, 32'h3);
    apbWrite(9'h00, 0);
    check("R8", "global disable", {31'b0, irq}, 0);
    apbWrite(9'h00, 1);
    check("R8", "global re-enable", {31'b0, irq}, 1);
    apbWrite(9'h3C, 32'h33);
    apbWrite(9'h2C, 1);
    check("R8", "all masked", {31'b0, irq}, 0);
    apbWrite(9'h3C, 32'h23);
    check("R8", "unmasked tx level", {31'b0, irq}, 1);
    apbWrite(9'h3C, 32'h13);
    check("R8", "tx overrun unmasked but clear", {31'b0, irq}, 0);
  endtask

  task automatic testParam;
    readCheck("R9", 9'h1F4, 32'h092407FE);
    readCheck("R9", 9'h1F0, 32'h00001224);
    apbWrite(9'h1F4, 32'h0);
    readCheck("R9", 9'h1F4, 32'h092407FE);
  endtask

  initial begin
    #(200000 * 4);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testCommon();
    testPairBank();
    testResolution();
    testFlush();
    testStatus();
    testOverrun();
    testIrq();
    testParam();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule